// File: doc/BRIEF.md
# Power-Domain Mission State Sequencer

This block keeps a power-delivery network in one of five mission states: standby, active, MCU-only, SoC error and retention. It also manages the hand-off with an outer, fixed hardware state machine that owns safe recovery. After reset, control sits with that outer machine. When the outer machine hands control over, the block first runs a three-step initialisation. The first step turns the rail residual-voltage checks off. The second sets a sticky first-startup flag. The third clears the supply over-voltage and under-voltage monitor mask. Only after that does the block settle in standby and start listening for an ON request.

In each mission state a fixed decode drives a ten-bit domain-enable vector and an external enable-drive pin. Retention comes in two variants, chosen by two bits of a trigger register written over the host bus. The DDR variant keeps the memory bias, memory core and external memory supply powered. The I/O variant keeps the MCU wake, MCU I/O, wake0 and I/O bank 2 domains powered. An error input, or loss of the valid-supply flag while in a mission state, starts a timed shutdown. The shutdown switches every domain off and then returns control to the outer machine with a one-cycle exit pulse.

Top module: `pwr_mission_seq`

## Requirements
- R1: After reset the state code (mstate) is 0 (outer control), dom_en is 0, en_drv is 0, rv_chk_off is 0, first_done is 0, vmon_mask is 1 and exit_pulse is 0. While in outer control, only handoff_in is acted on.
- R2: If handoff_in is high in outer control, the state code becomes 1 (init) at the next edge. rv_chk_off rises one edge later and first_done one edge after that. On the third edge after entry, vmon_mask clears and the state code becomes 2 (standby).
- R3: on_req is ignored during init. From standby, on_req moves the state to code 3 (active) at the next edge.
- R4: In standby dom_en is 0 and en_drv is 0.
- R5: In active dom_en is 10'h3FF and en_drv is 1. If on_req drops while no higher-priority condition holds, the next state is standby.
- R6: In active, mcu_only_req moves the state to code 4 (MCU-only). There dom_en is 10'h007 (bits 0..2: MCU wake, MCU I/O, MCU core) and en_drv is 1. When mcu_only_req drops, the state returns to active.
- R7: soc_fault in active or MCU-only moves the state to code 5 (SoC error). There dom_en is 10'h007 and en_drv is 0. When soc_fault clears, the state goes to MCU-only. In active, soc_fault has priority over the retention triggers, which have priority over mcu_only_req.
- R8: In active, a high ret_ddr_trig (trigger bit 7) or ret_io_trig (trigger bit 5) moves the state to code 6 (retention), where en_drv is 0. When both triggers are low, the state returns to active.
- R9: In DDR retention dom_en is 10'h0E0: bit 5 memory bias, bit 6 memory core, bit 7 external memory supply.
- R10: In I/O retention dom_en is 10'h01B: bit 0 MCU wake, bit 1 MCU I/O, bit 3 wake0, bit 4 I/O bank 2.
- R11: If both triggers are high on entry, the DDR variant is chosen. The variant is fixed at entry and stays unchanged while at least one trigger remains high.
- R12: err_in, or supply_ok low, in any of the codes 2..6 moves the state to code 7 (shutdown) at the next edge. Shutdown lasts SHUT_CYC cycles with dom_en 0 and en_drv 0. The state then returns to code 0 with exit_pulse high for exactly one cycle.
- R13: A later hand-off reruns init and lands in standby with all domains off. rv_chk_off and first_done stay set and vmon_mask stays clear throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | System supply above its under-voltage threshold |
| handoff_in | input | 1 | Outer machine hands control to the mission states |
| on_req | input | 1 | ON request |
| mcu_only_req | input | 1 | Request to power only the MCU group |
| soc_fault | input | 1 | SoC error indication |
| err_in | input | 1 | Error requiring shutdown and safe recovery |
| ret_ddr_trig | input | 1 | Trigger register bit 7: DDR retention |
| ret_io_trig | input | 1 | Trigger register bit 5: I/O retention |
| dom_en | output | 10 | Per-domain enable vector |
| en_drv | output | 1 | External enable drive |
| rv_chk_off | output | 1 | Residual-voltage checks disabled |
| first_done | output | 1 | First-startup-complete flag |
| vmon_mask | output | 1 | Supply OV/UV monitor mask |
| exit_pulse | output | 1 | One-cycle hand-back to the outer recovery machine |
| mstate | output | 3 | Current state code |

## Verification
The bench builds the block with SHUT_CYC set to 3. This keeps the timed shutdown short enough that one run covers both exit paths: supply loss from standby and err_in from active. Each path is followed by a full re-hand-off. Because the window is short, the exact edge of the exit pulse and the sticky init flags on a second init pass can be checked cycle by cycle, next to every variant and priority case of retention.

// File: rtl/pwr_mission_pkg.sv
package pwr_mission_pkg;
  localparam int NDOM = 10;

  typedef enum logic [2:0] {
    ST_OUTER    = 3'd0,
    ST_INIT     = 3'd1,
    ST_STANDBY  = 3'd2,
    ST_ACTIVE   = 3'd3,
    ST_MCU_ONLY = 3'd4,
    ST_SOC_ERR  = 3'd5,
    ST_RETAIN   = 3'd6,
    ST_SHUTDOWN = 3'd7
  } mstate_t;

  // domain bit order
  localparam int D_MCU_WAKE = 0;
  localparam int D_MCU_IO   = 1;
  localparam int D_MCU_CORE = 2;
  localparam int D_WAKE0    = 3;
  localparam int D_IO_BANK2 = 4;
  localparam int D_DDR_BIAS = 5;
  localparam int D_DDR_CORE = 6;
  localparam int D_EXT_MEM  = 7;
  localparam int D_MAIN_CPU = 8;
  localparam int D_MAIN_IO  = 9;

  localparam logic [NDOM-1:0] ONE = {{(NDOM-1){1'b0}}, 1'b1};
  localparam logic [NDOM-1:0] MASK_ALL = {NDOM{1'b1}};
  localparam logic [NDOM-1:0] MASK_MCU =
    (ONE << D_MCU_WAKE) | (ONE << D_MCU_IO) | (ONE << D_MCU_CORE);
  localparam logic [NDOM-1:0] MASK_RET_DDR =
    (ONE << D_DDR_BIAS) | (ONE << D_DDR_CORE) | (ONE << D_EXT_MEM);
  localparam logic [NDOM-1:0] MASK_RET_IO =
    (ONE << D_MCU_WAKE) | (ONE << D_MCU_IO) | (ONE << D_WAKE0) | (ONE << D_IO_BANK2);

  function automatic logic [NDOM-1:0] dom_mask(mstate_t s, logic ret_ddr);
    case (s)
      ST_ACTIVE:               return MASK_ALL;
      ST_MCU_ONLY, ST_SOC_ERR: return MASK_MCU;
      ST_RETAIN:               return ret_ddr ? MASK_RET_DDR : MASK_RET_IO;
      default:                 return '0;
    endcase
  endfunction

  function automatic logic drive_on(mstate_t s);
    return (s == ST_ACTIVE) || (s == ST_MCU_ONLY);
  endfunction

  function automatic logic is_mission(mstate_t s);
    return (s == ST_STANDBY) || (s == ST_ACTIVE) || (s == ST_MCU_ONLY) ||
           (s == ST_SOC_ERR) || (s == ST_RETAIN);
  endfunction
endpackage

// File: rtl/pwr_init_seq.sv
module pwr_init_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done,
  output logic rv_chk_off,
  output logic first_done,
  output logic vmon_mask
);
  localparam int NSTEP = 3;
  localparam int SW = $clog2(NSTEP);

  logic          busy;
  logic [SW-1:0] step;

  assign done = busy && (step == SW'(NSTEP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      step       <= '0;
      rv_chk_off <= 1'b0;
      first_done <= 1'b0;
      vmon_mask  <= 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      case (step)
        SW'(0): rv_chk_off <= 1'b1;
        SW'(1): first_done <= 1'b1;
        default: begin
          vmon_mask <= 1'b0;
          busy      <= 1'b0;
        end
      endcase
      step <= step + SW'(1);
    end
  end

  AST_INIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_done) |-> rv_chk_off); // R2
  AST_MASK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vmon_mask) |-> first_done && rv_chk_off); // R2
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
endmodule

// File: rtl/pwr_ret_sel.sv
module pwr_ret_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic ddr_trig,
  input  logic io_trig,
  output logic ret_req,
  output logic ret_ddr
);
  assign ret_req = ddr_trig | io_trig;

  always_ff @(posedge clk) begin
    if (!rst_n)       ret_ddr <= 1'b0;
    else if (capture) ret_ddr <= ddr_trig;
  end

  AST_DDR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    capture && ddr_trig && io_trig |=> ret_ddr); // R11
endmodule

// File: rtl/pwr_dom_decode.sv
module pwr_dom_decode
  import pwr_mission_pkg::*;
(
  input  mstate_t         state,
  input  logic            ret_ddr,
  output logic [NDOM-1:0] dom_en,
  output logic            en_drv
);
  always_comb begin
    dom_en = dom_mask(state, ret_ddr);
    en_drv = drive_on(state);
  end
endmodule

// File: rtl/pwr_mission_seq.sv
module pwr_mission_seq
  import pwr_mission_pkg::*;
#(
  parameter int SHUT_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_ok,
  input  logic            handoff_in,
  input  logic            on_req,
  input  logic            mcu_only_req,
  input  logic            soc_fault,
  input  logic            err_in,
  input  logic            ret_ddr_trig,
  input  logic            ret_io_trig,
  output logic [NDOM-1:0] dom_en,
  output logic            en_drv,
  output logic            rv_chk_off,
  output logic            first_done,
  output logic            vmon_mask,
  output logic            exit_pulse,
  output logic [2:0]      mstate
);
  localparam int CW = $clog2(SHUT_CYC + 1);

  mstate_t       state_q, state_d;
  logic [CW-1:0] shut_cnt;

  // named internal events
  logic fault_hit, init_go, init_done, shut_last, ret_enter, ret_req, ret_ddr;

  assign fault_hit = is_mission(state_q) && (err_in || !supply_ok);
  assign init_go   = (state_q == ST_OUTER) && handoff_in;
  assign shut_last = (state_q == ST_SHUTDOWN) && (shut_cnt == CW'(SHUT_CYC - 1));
  assign ret_enter = (state_q == ST_ACTIVE) && (state_d == ST_RETAIN);

  pwr_init_seq u_init (
    .clk(clk), .rst_n(rst_n), .start(init_go), .done(init_done),
    .rv_chk_off(rv_chk_off), .first_done(first_done), .vmon_mask(vmon_mask)
  );

  pwr_ret_sel u_ret (
    .clk(clk), .rst_n(rst_n), .capture(ret_enter),
    .ddr_trig(ret_ddr_trig), .io_trig(ret_io_trig),
    .ret_req(ret_req), .ret_ddr(ret_ddr)
  );

  pwr_dom_decode u_dec (
    .state(state_q), .ret_ddr(ret_ddr), .dom_en(dom_en), .en_drv(en_drv)
  );

  always_comb begin
    state_d = state_q;
    if (fault_hit) state_d = ST_SHUTDOWN;
    else begin
      case (state_q)
        ST_OUTER:    if (handoff_in) state_d = ST_INIT;
        ST_INIT:     if (init_done) state_d = ST_STANDBY;
        ST_STANDBY:  if (on_req) state_d = ST_ACTIVE;
        ST_ACTIVE: begin
          if (soc_fault)         state_d = ST_SOC_ERR;
          else if (ret_req)      state_d = ST_RETAIN;
          else if (mcu_only_req) state_d = ST_MCU_ONLY;
          else if (!on_req)      state_d = ST_STANDBY;
        end
        ST_MCU_ONLY: begin
          if (soc_fault)          state_d = ST_SOC_ERR;
          else if (!mcu_only_req) state_d = ST_ACTIVE;
        end
        ST_SOC_ERR:  if (!soc_fault) state_d = ST_MCU_ONLY;
        ST_RETAIN:   if (!ret_req) state_d = ST_ACTIVE;
        ST_SHUTDOWN: if (shut_last) state_d = ST_OUTER;
        default:     state_d = ST_OUTER;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_OUTER;
      shut_cnt   <= '0;
      exit_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      shut_cnt   <= (state_q == ST_SHUTDOWN) ? shut_cnt + CW'(1) : '0;
      exit_pulse <= shut_last;
    end
  end

  assign mstate = state_q;

  AST_ON_IGNORED_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_INIT |=> state_q != ST_ACTIVE); // R3
  AST_INIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STANDBY && $past(state_q) == ST_INIT) |->
      (rv_chk_off && first_done && !vmon_mask)); // R2
  AST_STBY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_STANDBY |-> (dom_en == '0 && !en_drv)); // R4
  AST_DRV_MCU: assert property (@(posedge clk) disable iff (!rst_n)
    en_drv |-> ((dom_en & MASK_MCU) == MASK_MCU)); // R6
  AST_RET_DRV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RETAIN |-> !en_drv); // R8
  AST_RET_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RETAIN |-> ($countones(dom_en) == (ret_ddr ? 3 : 4))); // R9
  AST_DDR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RETAIN && $past(state_q) == ST_ACTIVE && $past(ret_ddr_trig)) |->
      dom_en == MASK_RET_DDR); // R11
  AST_FAULT_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (state_q == ST_SHUTDOWN && dom_en == '0)); // R12
  AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pulse |-> (state_q == ST_OUTER && $past(state_q) == ST_SHUTDOWN)); // R12
endmodule

// File: tb/pwr_mission_seq_bench.sv
module pwr_mission_seq_bench;
  localparam int CLK_NS = 10;
  localparam int SHUT = 3;

  localparam logic [2:0] S_OUT = 0, S_INIT = 1, S_STBY = 2, S_ACT = 3,
                         S_MCU = 4, S_SOC = 5, S_RET = 6, S_SHUT = 7;
  localparam logic [9:0] D_OFF = 10'h000, D_ALL = 10'h3FF, D_MCU = 10'h007,
                         D_IO = 10'h01B, D_DDR = 10'h0E0;

  typedef struct {
    string      tag;
    int         due;
    logic [2:0] st;
    logic [9:0] dom;
    logic       drv;
    logic [2:0] flg;
    logic       xp;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, supply_ok, handoff_in, on_req, mcu_only_req, soc_fault, err_in;
  logic ret_ddr_trig, ret_io_trig;
  logic [9:0] dom_en;
  logic en_drv, rv_chk_off, first_done, vmon_mask, exit_pulse;
  logic [2:0] mstate;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  exp_t q[$];

  always #(CLK_NS / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_mission_seq #(.SHUT_CYC(SHUT)) u_pwr_mission_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .handoff_in(handoff_in),
    .on_req(on_req), .mcu_only_req(mcu_only_req), .soc_fault(soc_fault),
    .err_in(err_in), .ret_ddr_trig(ret_ddr_trig), .ret_io_trig(ret_io_trig),
    .dom_en(dom_en), .en_drv(en_drv), .rv_chk_off(rv_chk_off),
    .first_done(first_done), .vmon_mask(vmon_mask), .exit_pulse(exit_pulse),
    .mstate(mstate)
  );

  // monitor: compare every expected item due after the latest edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [2:0] f;
      e = q.pop_front();
      f = {rv_chk_off, first_done, vmon_mask};
      checks++;
      if (e.due != cyc || mstate !== e.st || dom_en !== e.dom || en_drv !== e.drv ||
          f !== e.flg || exit_pulse !== e.xp) begin
        failures++;
        $display("FAIL %s: st=%0d/%0d dom=%h/%h drv=%b/%b flg=%b/%b xp=%b/%b (act/exp)",
                 e.tag, mstate, e.st, dom_en, e.dom, en_drv, e.drv, f, e.flg,
                 exit_pulse, e.xp);
      end
    end
  end

  // driver: push the expectation for the next edge, then advance
  task automatic step_exp(string tag, logic [2:0] st, logic [9:0] dom, logic drv,
                          logic [2:0] flg, logic xp);
    exp_t e;
    e.tag = tag; e.due = cyc + 1; e.st = st; e.dom = dom;
    e.drv = drv; e.flg = flg; e.xp = xp;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung (act=timeout exp=finish)");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; supply_ok = 1; handoff_in = 0; on_req = 0; mcu_only_req = 0;
    soc_fault = 0; err_in = 0; ret_ddr_trig = 0; ret_io_trig = 0;
    @(negedge clk);
    step_exp("R1 reset", S_OUT, D_OFF, 0, 3'b001, 0);
    step_exp("R1 reset hold", S_OUT, D_OFF, 0, 3'b001, 0);
    rst_n = 1; on_req = 1;
    step_exp("R1 outer ignores on_req", S_OUT, D_OFF, 0, 3'b001, 0);

    handoff_in = 1;
    step_exp("R2 enter init", S_INIT, D_OFF, 0, 3'b001, 0);
    handoff_in = 0;
    step_exp("R2 rv checks off", S_INIT, D_OFF, 0, 3'b101, 0);
    step_exp("R3 on_req ignored in init", S_INIT, D_OFF, 0, 3'b111, 0);
    step_exp("R2 R4 standby after init", S_STBY, D_OFF, 0, 3'b110, 0);
    step_exp("R3 R5 active", S_ACT, D_ALL, 1, 3'b110, 0);

    mcu_only_req = 1;
    step_exp("R6 mcu only", S_MCU, D_MCU, 1, 3'b110, 0);
    mcu_only_req = 0;
    step_exp("R6 back to active", S_ACT, D_ALL, 1, 3'b110, 0);

    soc_fault = 1;
    step_exp("R7 soc error", S_SOC, D_MCU, 0, 3'b110, 0);
    step_exp("R7 soc error holds", S_SOC, D_MCU, 0, 3'b110, 0);
    soc_fault = 0;
    step_exp("R7 soc clear to mcu", S_MCU, D_MCU, 1, 3'b110, 0);
    step_exp("R6 mcu release", S_ACT, D_ALL, 1, 3'b110, 0);

    soc_fault = 1; ret_ddr_trig = 1; mcu_only_req = 1;
    step_exp("R7 soc beats retention", S_SOC, D_MCU, 0, 3'b110, 0);
    soc_fault = 0; ret_ddr_trig = 0; mcu_only_req = 0;
    step_exp("R7 soc exit", S_MCU, D_MCU, 1, 3'b110, 0);
    step_exp("R7 back active", S_ACT, D_ALL, 1, 3'b110, 0);

    ret_ddr_trig = 1; mcu_only_req = 1;
    step_exp("R8 R9 ddr retention over mcu", S_RET, D_DDR, 0, 3'b110, 0);
    mcu_only_req = 0; ret_ddr_trig = 0; ret_io_trig = 1;
    step_exp("R11 variant held", S_RET, D_DDR, 0, 3'b110, 0);
    ret_io_trig = 0;
    step_exp("R8 retention exit", S_ACT, D_ALL, 1, 3'b110, 0);

    ret_io_trig = 1;
    step_exp("R10 io retention", S_RET, D_IO, 0, 3'b110, 0);
    step_exp("R10 io retention holds", S_RET, D_IO, 0, 3'b110, 0);
    ret_io_trig = 0;
    step_exp("R8 io exit", S_ACT, D_ALL, 1, 3'b110, 0);

    ret_io_trig = 1; ret_ddr_trig = 1;
    step_exp("R11 both triggers pick ddr", S_RET, D_DDR, 0, 3'b110, 0);
    ret_io_trig = 0; ret_ddr_trig = 0;
    step_exp("R8 exit again", S_ACT, D_ALL, 1, 3'b110, 0);

    on_req = 0;
    step_exp("R5 on drop to standby", S_STBY, D_OFF, 0, 3'b110, 0);
    step_exp("R4 standby holds", S_STBY, D_OFF, 0, 3'b110, 0);

    supply_ok = 0;
    step_exp("R12 supply loss shutdown", S_SHUT, D_OFF, 0, 3'b110, 0);
    supply_ok = 1; on_req = 1;
    step_exp("R12 shutdown 2", S_SHUT, D_OFF, 0, 3'b110, 0);
    step_exp("R12 shutdown 3", S_SHUT, D_OFF, 0, 3'b110, 0);
    step_exp("R12 exit pulse", S_OUT, D_OFF, 0, 3'b110, 1);
    on_req = 0;
    step_exp("R12 pulse one cycle", S_OUT, D_OFF, 0, 3'b110, 0);

    handoff_in = 1;
    step_exp("R13 reinit", S_INIT, D_OFF, 0, 3'b110, 0);
    handoff_in = 0;
    step_exp("R13 reinit 2", S_INIT, D_OFF, 0, 3'b110, 0);
    step_exp("R13 reinit 3", S_INIT, D_OFF, 0, 3'b110, 0);
    step_exp("R13 standby all off", S_STBY, D_OFF, 0, 3'b110, 0);
    on_req = 1;
    step_exp("R13 active again", S_ACT, D_ALL, 1, 3'b110, 0);

    err_in = 1;
    step_exp("R12 error shutdown", S_SHUT, D_OFF, 0, 3'b110, 0);
    err_in = 0;
    step_exp("R12 err shut 2", S_SHUT, D_OFF, 0, 3'b110, 0);
    step_exp("R12 err shut 3", S_SHUT, D_OFF, 0, 3'b110, 0);
    step_exp("R12 err exit pulse", S_OUT, D_OFF, 0, 3'b110, 1);
    step_exp("R1 outer waits", S_OUT, D_OFF, 0, 3'b110, 0);

    @(negedge clk);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    summary();
    $finish;
  end
endmodule